// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarm

This block keeps wall-clock time for a chip. A strobe input marks each period of a 32.768 kHz reference inside the system clock domain; a programmable prescaler counts those strobes and produces one tick per second. Each tick advances a calendar held in two packed words. The date word holds year, month and day. The time word holds week of month, day of week, hour, minute and second. Month lengths and leap years are handled in hardware.

A comparator checks the calendar against a programmable alarm date and alarm time after each tick. Sticky event flags and their enables live in one status register and drive an alarm interrupt and a once-per-second interrupt. Software reaches everything through a simple single-cycle read/write port. Event flags clear only when a 1 is written to them, so software can rewrite the enables without losing a pending event.

Top module: `cal_rtc`

## Requirements
- R1: After reset the status register reads 0, the divider/trim register reads 0, the date word reads 0x00000021 (year 0, month 1, day 1) and the time word reads 0x00120000 (week 1, weekday 1, 00:00:00). Both interrupts are low.
- R2: Byte offsets are: status 0x08, divider/trim 0x0C, time word 0x10, date word 0x14, alarm time 0x18, alarm date 0x1C. The date word is year[20:9], month[8:5], day[4:0]. The time word is week-of-month[22:20], weekday[19:17], hour[16:12], minute[11:6], second[5:0]. The alarm words use the same layouts and read back what was written.
- R3: With a divider value D other than 0, the calendar advances one second every D+1 strobes. With D equal to 0, strobes leave the calendar unchanged.
- R4: The divider/trim register keeps the divider in bits 15:0 and the trim value in bits 31:16, and it reads back as written.
- R5: A tick advances the second. Seconds and minutes wrap from 59 to 0 and carry. Hours wrap from 23 to 0 and carry into the day. The weekday steps 1 to 7 and then back to 1.
- R6: The day wraps to 1 after the month's last day: 30 for months 4, 6, 9 and 11, 31 for the other months except February, and 29 for February when the year is divisible by 4 and not by 100, or divisible by 400, else 28. The month wraps from 12 to 1 and then increments the year.
- R7: Whenever the day changes on a tick, the week of month becomes (day+6)/7 using the new day.
- R8: Writing the time or date word loads it and restarts the prescaler. The next tick follows D+1 strobes after the write.
- R9: Status bit 1 (one-second flag) sets on every tick. irq_sec is high while bit 1 and bit 3 (one-second enable) are both set.
- R10: Status bits 0, 1 and 4 are flags. Writing 1 to a flag clears it and writing 0 leaves it unchanged. If a flag is set and cleared in the same cycle, the set wins. Bits 2, 3 and 5 are enables and take the written value.
- R11: In the cycle after a tick, if bit 5 (alarm enable) is set and both calendar words equal the alarm words, bits 4 and 0 set. irq_alarm is high while bit 4 is set, or while bit 0 and bit 2 are both set.
- R12: With bit 5 clear, a calendar match sets no flag.
- R13: If a time or date write happens in the same cycle as a tick, the written value is kept and the tick does not advance it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_en | input | 1 | One strobe per 32.768 kHz reference period |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not reading |
| irq_alarm | output | 1 | Alarm interrupt |
| irq_sec | output | 1 | Once-per-second interrupt |

## Verification
Two pairs of actions can fall in the same clock edge. The first pair is a tick and a status write that clears the one-second flag. The second pair is a tick and a write of the time word. The bench drives the strobe itself, so it knows the exact cycle in which the prescaler reaches the divider value. It places the bus write on that edge. Afterwards it requires the flag to still be set, and the time word to hold exactly the written value, then that value plus one second after the next full period.

// File: rtl/cal_rtc.sv
module cal_rtc #(
  parameter int ADDR_W = 6,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_alarm,
  output logic              irq_sec
);
  localparam int TRIM_W = 32 - DIV_W;
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_DIV   = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_TIME  = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] A_DATE  = ADDR_W'(20);
  localparam logic [ADDR_W-1:0] A_ATIME = ADDR_W'(24);
  localparam logic [ADDR_W-1:0] A_ADATE = ADDR_W'(28);

  logic [DIV_W-1:0]  div_q, cnt_q;
  logic [TRIM_W-1:0] trim_q;
  logic [11:0] yr;
  logic [3:0]  mo;
  logic [4:0]  dy, hr, mlen, nday;
  logic [2:0]  wom, dow, wom_n;
  logic [5:0]  mi, se, dsum;
  logic [20:0] adate;
  logic [22:0] atime;
  logic al_fl, hz_fl, a1_fl, al_en, hz_en, a1_en, tick_d;

  logic wr, wr_stat, wr_time, wr_date, cal_wr, tick, leap, set_a1;
  logic sec_wrap, min_wrap, hr_wrap, day_end, mon_end;
  logic [20:0] date_w;
  logic [22:0] time_w;

  assign wr      = bus_sel & bus_wr;
  assign wr_stat = wr & (bus_addr == A_STAT);
  assign wr_time = wr & (bus_addr == A_TIME);
  assign wr_date = wr & (bus_addr == A_DATE);
  assign cal_wr  = wr_time | wr_date;
  assign date_w  = {yr, mo, dy};
  assign time_w  = {wom, dow, hr, mi, se};
  assign tick    = slow_en & (div_q != '0) & (cnt_q >= div_q);

  assign leap     = ((yr[1:0] == 2'd0) && ((yr % 12'd100) != 12'd0)) || ((yr % 12'd400) == 12'd0);
  assign sec_wrap = se >= 6'd59;
  assign min_wrap = mi >= 6'd59;
  assign hr_wrap  = hr >= 5'd23;
  assign day_end  = dy >= mlen;
  assign mon_end  = mo >= 4'd12;
  assign nday     = day_end ? 5'd1 : dy + 5'd1;
  assign dsum     = {1'b0, nday} + 6'd6;
  assign wom_n    = 3'(dsum / 6'd7);

  always_comb begin
    case (mo)
      4'd2:                   mlen = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: mlen = 5'd30;
      default:                mlen = 5'd31;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (cal_wr || div_q == '0) cnt_q <= '0;
    else if (tick)                  cnt_q <= '0;
    else if (slow_en)               cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      yr <= '0; mo <= 4'd1; dy <= 5'd1;
      wom <= 3'd1; dow <= 3'd1; hr <= '0; mi <= '0; se <= '0;
    end else if (cal_wr) begin
      if (wr_date) {yr, mo, dy} <= bus_wdata[20:0];
      if (wr_time) {wom, dow, hr, mi, se} <= bus_wdata[22:0];
    end else if (tick) begin
      se <= sec_wrap ? 6'd0 : se + 6'd1;
      if (sec_wrap) begin
        mi <= min_wrap ? 6'd0 : mi + 6'd1;
        if (min_wrap) begin
          hr <= hr_wrap ? 5'd0 : hr + 5'd1;
          if (hr_wrap) begin
            dow <= (dow >= 3'd7) ? 3'd1 : dow + 3'd1;
            dy  <= nday;
            wom <= wom_n;
            if (day_end) begin
              mo <= mon_end ? 4'd1 : mo + 4'd1;
              if (mon_end) yr <= yr + 12'd1;
            end
          end
        end
      end
    end
  end

  assign set_a1 = tick_d & a1_en & (date_w == adate) & (time_w == atime);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {al_fl, hz_fl, a1_fl, al_en, hz_en, a1_en, tick_d} <= '0;
      div_q <= '0; trim_q <= '0; adate <= '0; atime <= '0;
    end else begin
      tick_d <= tick & ~cal_wr;
      al_fl  <= set_a1 | (al_fl & ~(wr_stat & bus_wdata[0]));
      hz_fl  <= tick   | (hz_fl & ~(wr_stat & bus_wdata[1]));
      a1_fl  <= set_a1 | (a1_fl & ~(wr_stat & bus_wdata[4]));
      if (wr_stat) {a1_en, hz_en, al_en} <= {bus_wdata[5], bus_wdata[3], bus_wdata[2]};
      if (wr && bus_addr == A_DIV) {trim_q, div_q} <= bus_wdata;
      if (wr && bus_addr == A_ATIME) atime <= bus_wdata[22:0];
      if (wr && bus_addr == A_ADATE) adate <= bus_wdata[20:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        A_STAT:  bus_rdata = {26'd0, a1_en, a1_fl, hz_en, al_en, hz_fl, al_fl};
        A_DIV:   bus_rdata = {trim_q, div_q};
        A_TIME:  bus_rdata = {9'd0, time_w};
        A_DATE:  bus_rdata = {11'd0, date_w};
        A_ATIME: bus_rdata = {9'd0, atime};
        A_ADATE: bus_rdata = {11'd0, adate};
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq_alarm = a1_fl | (al_fl & al_en);
  assign irq_sec   = hz_fl & hz_en;

  assert_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0 && !cal_wr) |=> $stable(time_w));
  assert_sec_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cal_wr) |=> (se == 6'd0 || se == $past(se) + 6'd1));
  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cal_wr |=> (cnt_q == '0));
  assert_hz_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> hz_fl);
  assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[1] && !tick) |=> !hz_fl);
  assert_alarm_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a1_fl) |-> $past(a1_en));
endmodule

// File: tb/sim_cal_rtc.sv
`timescale 1ns/1ps
module sim_cal_rtc;
  logic clk = 1'b0, rst_n = 1'b0, slow_en = 1'b0, bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_alarm, irq_sec;

  cal_rtc u0 (.clk(clk), .rst_n(rst_n), .slow_en(slow_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
              .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
              .irq_alarm(irq_alarm), .irq_sec(irq_sec));

  always #2 clk = ~clk;

  localparam logic [5:0] STAT = 6'h08, DIVR = 6'h0C, TIMW = 6'h10, DATW = 6'h14, ATIM = 6'h18, ADAT = 6'h1C;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  bit          kind_q[$];
  string       tag_q[$];
  event smp;

  function automatic logic [31:0] mk_date(int y, int m, int d);
    return (y << 9) | (m << 5) | d;
  endfunction
  function automatic logic [31:0] mk_time(int w, int dw, int h, int m, int s);
    return (w << 20) | (dw << 17) | (h << 12) | (m << 6) | s;
  endfunction

  always begin
    @(smp);
    begin
      logic [31:0] e, a;
      bit k;
      string t;
      e = exp_q.pop_front(); k = kind_q.pop_front(); t = tag_q.pop_front();
      a = k ? {30'd0, irq_alarm, irq_sec} : bus_rdata;
      n_chk++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", t, a, e);
      end
    end
  end

  task automatic bus_write(logic [5:0] ad, logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = ad; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic expect_rd(logic [5:0] ad, logic [31:0] e, string t);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = ad;
    exp_q.push_back(e); kind_q.push_back(1'b0); tag_q.push_back(t);
    #0.5 -> smp;
    #0.5 bus_sel = 0;
  endtask

  task automatic expect_irq(logic [1:0] e, string t);
    @(negedge clk);
    exp_q.push_back({30'd0, e}); kind_q.push_back(1'b1); tag_q.push_back(t);
    #0.5 -> smp;
    #0.5;
  endtask

  task automatic strobe(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); slow_en = 1; end
    @(negedge clk); slow_en = 0;
  endtask

  task automatic advance(int secs);
    strobe(2 * secs);
    @(negedge clk);
  endtask

  task automatic cal_case(logic [31:0] d, logic [31:0] t, logic [31:0] de, logic [31:0] te, string tag);
    bus_write(DATW, d); bus_write(TIMW, t);
    advance(1);
    expect_rd(DATW, de, tag); expect_rd(TIMW, te, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    expect_rd(STAT, 32'h0, "R1 status");
    expect_rd(DIVR, 32'h0, "R1 divider");
    expect_rd(DATW, 32'h21, "R1 date");
    expect_rd(TIMW, 32'h00120000, "R1 time");
    expect_irq(2'b00, "R1 irq");
    // R3 divider 0 holds
    strobe(5);
    expect_rd(TIMW, 32'h00120000, "R3 stopped");
    // R4 readback
    bus_write(DIVR, 32'h0005_0002);
    expect_rd(DIVR, 32'h0005_0002, "R4 trim/div");
    // R3/R8 with D=2
    bus_write(TIMW, mk_time(1, 2, 10, 20, 30));
    strobe(2);
    expect_rd(TIMW, mk_time(1, 2, 10, 20, 30), "R3 short of period");
    strobe(1);
    expect_rd(TIMW, mk_time(1, 2, 10, 20, 31), "R3 one period");
    strobe(1);
    bus_write(TIMW, mk_time(1, 2, 9, 0, 0));
    strobe(2);
    expect_rd(TIMW, mk_time(1, 2, 9, 0, 0), "R8 restart no early tick");
    strobe(1);
    expect_rd(TIMW, mk_time(1, 2, 9, 0, 1), "R8 tick after full period");
    // remaining tests at D=1
    bus_write(DIVR, 32'h0000_0001);
    cal_case(mk_date(2024, 3, 5), mk_time(1, 3, 10, 59, 59), mk_date(2024, 3, 5), mk_time(1, 3, 11, 0, 0), "R5 hour carry");
    cal_case(mk_date(2024, 3, 5), mk_time(1, 3, 0, 0, 59), mk_date(2024, 3, 5), mk_time(1, 3, 0, 1, 0), "R5 minute carry");
    cal_case(mk_date(1999, 12, 31), mk_time(5, 7, 23, 59, 59), mk_date(2000, 1, 1), mk_time(1, 1, 0, 0, 0), "R5 R6 year wrap");
    cal_case(mk_date(2000, 2, 28), mk_time(4, 3, 23, 59, 59), mk_date(2000, 2, 29), mk_time(5, 4, 0, 0, 0), "R6 leap 400");
    cal_case(mk_date(2000, 2, 29), mk_time(5, 4, 23, 59, 59), mk_date(2000, 3, 1), mk_time(1, 5, 0, 0, 0), "R6 leap end");
    cal_case(mk_date(1900, 2, 28), mk_time(4, 1, 23, 59, 59), mk_date(1900, 3, 1), mk_time(1, 2, 0, 0, 0), "R6 century");
    cal_case(mk_date(2023, 2, 28), mk_time(4, 3, 23, 59, 59), mk_date(2023, 3, 1), mk_time(1, 4, 0, 0, 0), "R6 common year");
    cal_case(mk_date(2024, 2, 28), mk_time(4, 3, 23, 59, 59), mk_date(2024, 2, 29), mk_time(5, 4, 0, 0, 0), "R6 leap 4");
    cal_case(mk_date(2024, 4, 30), mk_time(5, 3, 23, 59, 59), mk_date(2024, 5, 1), mk_time(1, 4, 0, 0, 0), "R6 30-day");
    cal_case(mk_date(2024, 1, 31), mk_time(5, 4, 23, 59, 59), mk_date(2024, 2, 1), mk_time(1, 5, 0, 0, 0), "R6 31-day");
    cal_case(mk_date(2024, 3, 7), mk_time(1, 5, 23, 59, 59), mk_date(2024, 3, 8), mk_time(2, 6, 0, 0, 0), "R7 week 2");
    cal_case(mk_date(2024, 1, 28), mk_time(4, 1, 23, 59, 59), mk_date(2024, 1, 29), mk_time(5, 2, 0, 0, 0), "R7 week 5");
    // R9 / R10
    expect_rd(STAT, 32'h02, "R9 flag set by ticks");
    bus_write(STAT, 32'h0);
    expect_rd(STAT, 32'h02, "R10 write 0 keeps flag");
    bus_write(STAT, 32'h2);
    expect_rd(STAT, 32'h00, "R10 write 1 clears");
    bus_write(STAT, 32'h8);
    expect_irq(2'b00, "R9 enable without flag");
    advance(1);
    expect_rd(STAT, 32'h0A, "R9 flag with enable");
    expect_irq(2'b01, "R9 irq_sec");
    bus_write(STAT, 32'h0A);
    expect_rd(STAT, 32'h08, "R10 clear keeps enable");
    expect_irq(2'b00, "R9 irq_sec drops");
    // R12 match without enable
    bus_write(STAT, 32'h02);
    bus_write(DATW, mk_date(2024, 6, 15));
    bus_write(TIMW, mk_time(3, 7, 8, 0, 0));
    bus_write(ADAT, mk_date(2024, 6, 15));
    bus_write(ATIM, mk_time(3, 7, 8, 0, 2));
    expect_rd(ADAT, mk_date(2024, 6, 15), "R2 alarm date");
    expect_rd(ATIM, mk_time(3, 7, 8, 0, 2), "R2 alarm time");
    advance(2);
    expect_rd(STAT, 32'h02, "R12 no flag when disabled");
    expect_irq(2'b00, "R12 irq low");
    // R11
    bus_write(TIMW, mk_time(3, 7, 8, 0, 0));
    bus_write(STAT, 32'h22);
    expect_rd(STAT, 32'h20, "R10 enable write");
    advance(1);
    expect_rd(STAT, 32'h22, "R11 no early match");
    advance(1);
    expect_rd(STAT, 32'h33, "R11 match flags");
    expect_irq(2'b10, "R11 irq_alarm");
    bus_write(STAT, 32'h24);
    expect_rd(STAT, 32'h37, "R10 flags kept by 0");
    bus_write(STAT, 32'h34);
    expect_rd(STAT, 32'h27, "R10 clear bit4 only");
    expect_irq(2'b10, "R11 irq via bit0 and bit2");
    bus_write(STAT, 32'h21);
    expect_rd(STAT, 32'h22, "R10 clear bit0");
    expect_irq(2'b00, "R11 irq_alarm low");
    // collisions
    bus_write(STAT, 32'h02);
    expect_rd(STAT, 32'h00, "R10 cleared before collision");
    @(negedge clk); slow_en = 1;
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = STAT; bus_wdata = 32'h02;
    @(negedge clk); slow_en = 0; bus_sel = 0; bus_wr = 0;
    expect_rd(STAT, 32'h02, "R10 set wins over clear");
    @(negedge clk); slow_en = 1;
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = TIMW; bus_wdata = mk_time(1, 1, 5, 5, 5);
    @(negedge clk); slow_en = 0; bus_sel = 0; bus_wr = 0;
    expect_rd(TIMW, mk_time(1, 1, 5, 5, 5), "R13 write wins over tick");
    advance(1);
    expect_rd(TIMW, mk_time(1, 1, 5, 5, 6), "R13 R8 next second");
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule